// File: doc/BRIEF.md
# Radix Page-Table Walker with Merged Table Levels

This block translates a 48-bit virtual address into a physical address. It reads one 8-byte descriptor from memory per step, walking a four-level radix tree of translation tables. A regular table occupies one 4 KiB page and is indexed by 9 address bits. Any table descriptor may set a flag declaring that its child is a merged table: a single 2 MiB table that holds two levels at once. The walker indexes a merged table with 18 address bits and moves down two levels for the cost of one memory read. A walk over fully merged tables therefore finishes in two reads instead of four. Descriptors with the flag clear give an ordinary one-level step, so trees whose merged tables have been split back into regular ones keep working with no change of mode.

A client issues one request at a time and receives a single-cycle response that carries the physical address, the page size and a fault indication. The root table base address and a flag marking the root as merged are configuration inputs. Memory is a read port with a ready handshake on the request side and a response that may arrive any number of cycles later.

Top module: `xlat_walker`

## Requirements
- R1: After reset, req_ready is 1, and rsp_valid and mem_req_valid are 0. While req_ready is 1, no memory read is requested.
- R2: Descriptor fields: bit 0 is valid, bit 1 is type (table/page when set, block when clear), bit 2 is next-table-merged, and bits 47:12 hold the output address. A regular table starting at level L is read at base + 8 × VA[47−9L −: 9]. Levels are 0 (root) to 3.
- R3: A merged table starting at level L is read at base + 8 × VA[47−9L −: 18], and its descriptor counts as level L+1. A table descriptor with the merged bit set at level 0 or 1 makes its child such a table.
- R4: When cfg_root_large is 1, the first read treats the root as a merged table covering levels 0 and 1.
- R5: A table descriptor with the merged bit clear at level 0, 1 or 2 leads to a regular child table one level down.
- R6: A descriptor with type and merged bits both set at level 2 ends the walk as a 2 MiB page. At level 3 the merged bit has no effect.
- R7: A descriptor with the valid bit clear ends the walk with rsp_fault = 1, rsp_fault_lvl = its level and rsp_pa = 0. Its other bits are ignored. A valid block descriptor (type clear) at level 0, or a valid descriptor with type clear at level 3, also faults at that level.
- R8: A valid block descriptor at level 1 ends the walk as a 1 GiB page. At level 2 it ends the walk as a 2 MiB page. A valid descriptor with type set at level 3 is a 4 KiB page.
- R9: rsp_size encodes 0 = 4 KiB, 1 = 2 MiB and 2 = 1 GiB. rsp_pa takes its bits above the page offset from the descriptor and its offset bits (11:0, 20:0 or 29:0) from the VA. Descriptor bits 63:48 are ignored.
- R10: The walk issues exactly one read per table visited, so a fully merged path takes two reads.
- R11: Once a request is accepted, req_ready stays 0 until the response has been given. rsp_valid is a one-cycle pulse in the cycle after the final descriptor returns.
- R12: mem_req_valid and mem_req_addr hold steady until mem_req_ready is seen. The walker waits any number of cycles for mem_rsp_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_root_base | input | 48 | Physical base of the root table |
| cfg_root_large | input | 1 | Root table is merged (levels 0 and 1) |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 48 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pa | output | 48 | Translated physical address (0 on fault) |
| rsp_size | output | 2 | Page size code |
| rsp_fault | output | 1 | Translation fault |
| rsp_fault_lvl | output | 2 | Level of the faulting descriptor |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 48 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Descriptor data present |
| mem_rsp_data | input | 64 | Descriptor returned by memory |

## Verification
A descriptor read is requested in the first cycle after a request is accepted. The next read is requested in the cycle after each non-final descriptor returns. The response strobe rises in the cycle after the final descriptor returns. The bench's memory model stamps the clock edge at which each descriptor is consumed and checks that the response is seen exactly one cycle later. It also compares every read address and the read count with the path it built. It sweeps every sequence of descriptor kinds over four steps, with the root both regular and merged, under a memory that varies its ready and its latency.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int VA_W       = 48;
  localparam int PA_W       = 48;
  localparam int DESC_W     = 64;
  localparam int PG_SHIFT   = 12;
  localparam int IDX_W      = 9;
  localparam int N_LVL      = 4;
  localparam int LVL_W      = $clog2(N_LVL);
  localparam int ENTRY_LOG  = 3;
  localparam int WIDE_IDX_W = 2 * IDX_W;

  localparam int B_VALID = 0;
  localparam int B_TABLE = 1;
  localparam int B_LARGE = 2;

  typedef logic [VA_W-1:0]   va_t;
  typedef logic [PA_W-1:0]   pa_t;
  typedef logic [DESC_W-1:0] desc_t;
  typedef logic [LVL_W-1:0]  lvl_t;

  typedef enum logic [1:0] {SZ_4K = 2'd0, SZ_2M = 2'd1, SZ_1G = 2'd2} pgsz_e;
  typedef enum logic [1:0] {DK_FAULT, DK_LEAF, DK_NEXT, DK_NEXT_WIDE} dkind_e;
  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DONE} wstate_e;

  // Shift that brings the lowest index field of a table to bit 0.
  function automatic int unsigned idx_shift(lvl_t lvl, logic wide);
    return PG_SHIFT + IDX_W * (N_LVL - 1 - int'(lvl) - int'(wide));
  endfunction

  function automatic pa_t entry_addr(pa_t base, va_t va, lvl_t lvl, logic wide);
    va_t sh;
    logic [WIDE_IDX_W-1:0] idx;
    sh  = va >> idx_shift(lvl, wide);
    idx = wide ? sh[WIDE_IDX_W-1:0] : {{IDX_W{1'b0}}, sh[IDX_W-1:0]};
    return base + (pa_t'(idx) << ENTRY_LOG);
  endfunction

  function automatic int unsigned offset_bits(pgsz_e sz);
    return PG_SHIFT + IDX_W * int'(sz);
  endfunction

  function automatic pa_t splice_pa(desc_t d, va_t va, pgsz_e sz);
    pa_t m;
    m = (pa_t'(1) << offset_bits(sz)) - pa_t'(1);
    return (d[PA_W-1:0] & ~m) | (pa_t'(va) & m);
  endfunction

  function automatic pa_t child_base(desc_t d);
    return {d[PA_W-1:PG_SHIFT], {PG_SHIFT{1'b0}}};
  endfunction
endpackage

// File: rtl/xw_addr_gen.sv
module xw_addr_gen
  import xw_pkg::*;
(
  input  pa_t  base,
  input  va_t  va,
  input  lvl_t lvl,
  input  logic wide,
  output pa_t  addr
);
  always_comb addr = entry_addr(base, va, lvl, wide);
endmodule

// File: rtl/xw_desc_decode.sv
module xw_desc_decode
  import xw_pkg::*;
(
  input  desc_t  desc,
  input  lvl_t   dlvl,
  output dkind_e kind,
  output pgsz_e  size
);
  logic v, t, lg;
  assign v  = desc[B_VALID];
  assign t  = desc[B_TABLE];
  assign lg = desc[B_LARGE];

  always_comb begin
    kind = DK_FAULT;
    size = SZ_4K;
    if (v) begin
      if (dlvl == lvl_t'(N_LVL - 1)) begin
        kind = t ? DK_LEAF : DK_FAULT;
        size = SZ_4K;
      end else if (!t) begin
        case (dlvl)
          lvl_t'(1): begin kind = DK_LEAF; size = SZ_1G; end
          lvl_t'(2): begin kind = DK_LEAF; size = SZ_2M; end
          default:   kind = DK_FAULT;
        endcase
      end else if (lg) begin
        if (dlvl == lvl_t'(N_LVL - 2)) begin
          kind = DK_LEAF;
          size = SZ_2M;
        end else begin
          kind = DK_NEXT_WIDE;
        end
      end else begin
        kind = DK_NEXT;
      end
    end
  end
endmodule

// File: rtl/xw_result_fmt.sv
module xw_result_fmt
  import xw_pkg::*;
(
  input  desc_t desc,
  input  va_t   va,
  input  pgsz_e size,
  input  logic  fault,
  output pa_t   pa
);
  always_comb pa = fault ? '0 : splice_pa(desc, va, size);
endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
  import xw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] cfg_root_base,
  input  logic        cfg_root_large,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [47:0] req_va,
  output logic        rsp_valid,
  output logic [47:0] rsp_pa,
  output logic [1:0]  rsp_size,
  output logic        rsp_fault,
  output logic [1:0]  rsp_fault_lvl,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [47:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data
);
  wstate_e state_q;
  va_t     va_q;
  pa_t     base_q;
  lvl_t    lvl_q;
  logic    wide_q;
  pa_t     pa_q;
  pgsz_e   size_q;
  logic    fault_q;
  lvl_t    flvl_q;

  lvl_t    dlvl;
  dkind_e  kind;
  pgsz_e   leaf_size;
  pa_t     leaf_pa;
  pa_t     rd_addr;

  // Named internal events, visible to the bound checker
  logic ev_accept, ev_desc_in, ev_descend_narrow, ev_descend_wide, ev_finish;

  assign dlvl = lvl_q + lvl_t'(wide_q);

  xw_addr_gen u_addr (
    .base (base_q),
    .va   (va_q),
    .lvl  (lvl_q),
    .wide (wide_q),
    .addr (rd_addr)
  );

  xw_desc_decode u_dec (
    .desc (mem_rsp_data),
    .dlvl (dlvl),
    .kind (kind),
    .size (leaf_size)
  );

  xw_result_fmt u_fmt (
    .desc  (mem_rsp_data),
    .va    (va_q),
    .size  (leaf_size),
    .fault (kind == DK_FAULT),
    .pa    (leaf_pa)
  );

  assign ev_accept         = (state_q == S_IDLE) && req_valid;
  assign ev_desc_in        = (state_q == S_WAIT) && mem_rsp_valid;
  assign ev_descend_narrow = ev_desc_in && (kind == DK_NEXT);
  assign ev_descend_wide   = ev_desc_in && (kind == DK_NEXT_WIDE);
  assign ev_finish         = ev_desc_in && (kind == DK_LEAF || kind == DK_FAULT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      va_q    <= '0;
      base_q  <= '0;
      lvl_q   <= '0;
      wide_q  <= 1'b0;
      pa_q    <= '0;
      size_q  <= SZ_4K;
      fault_q <= 1'b0;
      flvl_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (ev_accept) begin
          va_q    <= req_va;
          base_q  <= cfg_root_base;
          lvl_q   <= '0;
          wide_q  <= cfg_root_large;
          state_q <= S_ISSUE;
        end
        S_ISSUE: if (mem_req_ready) state_q <= S_WAIT;
        S_WAIT: begin
          if (ev_descend_narrow || ev_descend_wide) begin
            base_q  <= child_base(mem_rsp_data);
            lvl_q   <= dlvl + lvl_t'(1);
            wide_q  <= ev_descend_wide;
            state_q <= S_ISSUE;
          end else if (ev_finish) begin
            pa_q    <= leaf_pa;
            fault_q <= (kind == DK_FAULT);
            size_q  <= (kind == DK_FAULT) ? SZ_4K : leaf_size;
            flvl_q  <= (kind == DK_FAULT) ? dlvl : lvl_t'(0);
            state_q <= S_DONE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign req_ready     = (state_q == S_IDLE);
  assign mem_req_valid = (state_q == S_ISSUE);
  assign mem_req_addr  = rd_addr;
  assign rsp_valid     = (state_q == S_DONE);
  assign rsp_pa        = pa_q;
  assign rsp_size      = size_q;
  assign rsp_fault     = fault_q;
  assign rsp_fault_lvl = flvl_q;
endmodule

// File: rtl/xlat_walker_chk.sv
module xlat_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_root_large,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_fault,
  input logic [47:0] rsp_pa,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [47:0] mem_req_addr,
  input logic [1:0]  lvl_q,
  input logic        wide_q,
  input logic        ev_descend_narrow,
  input logic        ev_descend_wide
);
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_req_valid && !rsp_valid));

  p_wide_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_descend_wide |=> (wide_q && lvl_q == ($past(lvl_q) + 2'($past(wide_q)) + 2'd1)));

  p_root_merge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (lvl_q == 2'd0 && wide_q == $past(cfg_root_large)));

  p_narrow_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_descend_narrow |=> (!wide_q && lvl_q == ($past(lvl_q) + 2'($past(wide_q)) + 2'd1)));

  p_fault_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_pa == 48'd0));

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind xlat_walker xlat_walker_chk u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .cfg_root_large    (cfg_root_large),
  .req_valid         (req_valid),
  .req_ready         (req_ready),
  .rsp_valid         (rsp_valid),
  .rsp_fault         (rsp_fault),
  .rsp_pa            (rsp_pa),
  .mem_req_valid     (mem_req_valid),
  .mem_req_ready     (mem_req_ready),
  .mem_req_addr      (mem_req_addr),
  .lvl_q             (lvl_q),
  .wide_q            (wide_q),
  .ev_descend_narrow (ev_descend_narrow),
  .ev_descend_wide   (ev_descend_wide)
);

// File: tb/xlat_walker_test.sv
`timescale 1ns/1ps
module xlat_walker_test;
  localparam logic [47:0] ROOT = 48'h0000_1000_0000;
  localparam logic [47:0] TBL0 = 48'h0000_4000_0000;
  localparam logic [47:0] HUGE = 48'h0000_0020_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_root_large = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_va = '0;
  logic        rsp_valid;
  logic [47:0] rsp_pa;
  logic [1:0]  rsp_size;
  logic        rsp_fault;
  logic [1:0]  rsp_fault_lvl;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #10 clk = ~clk;

  xlat_walker uut (
    .clk(clk), .rst_n(rst_n), .cfg_root_base(ROOT), .cfg_root_large(cfg_root_large),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_size(rsp_size),
    .rsp_fault(rsp_fault), .rsp_fault_lvl(rsp_fault_lvl),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit summed = 0;

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!summed) begin
      summed = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    end
  endtask

  // Memory model: descriptor store, variable ready and latency, read log
  logic [63:0] mem [logic [47:0]];
  logic [47:0] got_addr [8];
  int          got_n = 0;
  int          cyc = 0;
  int          last_rsp_cyc = 0;
  bit          pend = 0;
  logic [47:0] paddr = '0;
  int          lat = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    mem_req_ready <= (cyc % 3) != 1;
    if (mem_rsp_valid) last_rsp_cyc <= cyc;
    mem_rsp_valid <= 1'b0;
    if (mem_req_valid && mem_req_ready) begin
      pend  <= 1;
      paddr <= mem_req_addr;
      lat   <= cyc % 4;
      if (got_n < 8) got_addr[got_n] <= mem_req_addr;
      got_n <= got_n + 1;
    end else if (pend) begin
      if (lat == 0) begin
        pend          <= 0;
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem.exists(paddr) ? mem[paddr] : 64'h0;
      end else begin
        lat <= lat - 1;
      end
    end
  end

  // Build one path from a code (two bits of descriptor kind per step) and run it
  task automatic run_walk(int code, bit rl, logic [47:0] va);
    logic [47:0] base, addr, outa, exp_pa;
    logic [47:0] exp_addr [4];
    logic [63:0] d;
    int L, D, n, k;
    bit W, done, e_fault;
    logic [1:0] e_size, e_lvl, kd;
    mem.delete();
    base = ROOT; L = 0; W = rl; n = 0; done = 0;
    e_fault = 0; e_size = 2'd0; e_lvl = 2'd0; exp_pa = '0;
    outa = {36'h9A5C31E70 ^ 36'(code * 7 + int'(rl)), 12'h000};
    for (k = 0; k < 4; k++) begin
      if (!done) begin
        D = L + int'(W);
        if (W) addr = base + {27'b0, va[47-9*L -: 18], 3'b000};  // R3 merged index
        else   addr = base + {36'b0, va[47-9*L -: 9], 3'b000};   // R2 regular index
        exp_addr[n] = addr;
        n++;
        kd = 2'(code >> (2*k));
        if (kd == 2'd0) begin
          d = 64'hFFFF_FFFF_FFFF_FFFE;                 // R7 invalid, other bits set
          e_fault = 1; e_lvl = 2'(D); done = 1;
        end else if (D == 3) begin
          if (kd == 2'd3) begin d = {16'hC0DE, outa} | 64'h1; e_fault = 1; e_lvl = 2'd3; end
          else begin d = {16'hC0DE, outa} | (kd == 2'd2 ? 64'h7 : 64'h3); e_size = 2'd0; end
          done = 1;                                     // R6 merged bit ignored at L3
        end else if (kd == 2'd3) begin
          d = {16'hC0DE, outa} | 64'h1;                // R8 block
          if (D == 0) begin e_fault = 1; e_lvl = 2'd0; end
          else e_size = (D == 1) ? 2'd2 : 2'd1;
          done = 1;
        end else if (kd == 2'd2 && D == 2) begin
          d = {16'hC0DE, outa} | 64'h7;                // R6 merged at L2 is a 2 MiB page
          e_size = 2'd1; done = 1;
        end else begin
          base = TBL0 + HUGE * 48'(n);
          d = {16'hC0DE, base} | (kd == 2'd2 ? 64'h7 : 64'h3);
          L = D + 1; W = (kd == 2'd2);                 // R3 / R5 descent
        end
        mem[addr] = d;
      end
    end
    if (!e_fault) begin
      case (e_size)
        2'd0:    exp_pa = {outa[47:12], va[11:0]};
        2'd1:    exp_pa = {outa[47:21], va[20:0]};
        default: exp_pa = {outa[47:30], va[29:0]};
      endcase
    end

    @(negedge clk);
    cfg_root_large = rl;
    check(req_ready == 1'b1, "R11", "ready before request", 64'(req_ready), 64'h1);
    got_n = 0;
    req_va = va;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R11", "ready while busy", 64'(req_ready), 64'h0);
    begin
      int w;
      w = 0;
      while (!rsp_valid && w < 300) begin
        @(negedge clk);
        w++;
        if (!rsp_valid && req_ready) check(0, "R11", "ready rose early", 64'h1, 64'h0);
      end
      if (!rsp_valid) begin
        check(0, "R12", "walk timeout", 64'(w), 64'd300);
        return;
      end
    end
    check(cyc == last_rsp_cyc + 1, "R11", "response one cycle after last descriptor",
          64'(cyc - last_rsp_cyc), 64'd1);
    check(rsp_fault == e_fault, "R7", "fault", 64'(rsp_fault), 64'(e_fault));
    if (e_fault) begin
      check(rsp_fault_lvl == e_lvl, "R7", "fault level", 64'(rsp_fault_lvl), 64'(e_lvl));
      check(rsp_pa == 48'd0, "R7", "pa on fault", 64'(rsp_pa), 64'h0);
    end else begin
      check(rsp_size == e_size, "R8", "page size", 64'(rsp_size), 64'(e_size));
      check(rsp_pa == exp_pa, "R9", "physical address", 64'(rsp_pa), 64'(exp_pa));
    end
    check(got_n == n, "R10", "read count", 64'(got_n), 64'(n));
    for (int i = 0; i < 4; i++)
      if (i < n && i < got_n)
        check(got_addr[i] == exp_addr[i], (i == 0 && rl) ? "R4" : "R2", "read address",
              64'(got_addr[i]), 64'(exp_addr[i]));
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11", "response pulse width", 64'(rsp_valid), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(0, "R12", "watchdog expired", 64'h0, 64'h1);
    summary();
    $finish;
  end

  initial begin
    logic [63:0] s;
    s = 64'h1234_5678_9ABC_DEF1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(req_ready == 1'b1, "R1", "req_ready after reset", 64'(req_ready), 64'h1);
    check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", 64'(rsp_valid), 64'h0);
    check(mem_req_valid == 1'b0, "R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'h0);
    for (int rl = 0; rl < 2; rl++)
      for (int code = 0; code < 256; code++) begin
        s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
        run_walk(code, rl[0], s[63:16]);
      end
    summary();
    $finish;
  end
endmodule